// File: doc/BRIEF.md
# Overcurrent Qualifier with Automatic Retry

This block sits beside one power output and decides whether that output may be driven. It receives a raw overcurrent flag from an analog comparator. The flag has to stay high for a set number of time-base ticks while the output is on. When it does, the block latches an overcurrent status bit and removes the drive. The status bit stays set until software strobes a clear.

When recovery mode is enabled at the moment a fault is qualified, the output is not left off. A retry period timer starts instead. The output is switched back on for a short window at the end of each period. The result is a pulsed current that lets a load with a high inrush current (a cold lamp, a stalled motor, a cold heater) reach its operating point. The retry period has two settings, a slow one (about 3 kHz) and a fast one (about 6 kHz). The on-window is one eighth or one quarter of the period, which gives roughly 12 % or 25 %. All time constants are counts of a single enable tick, so one tick rate sets every timing.

Top module: `ocp_retry_ctrl`

## Requirements
- R1: The status bit sets, and the drive drops, only after `oc_raw` has been high while `drv_en` was high on QUAL_TICKS consecutive tick cycles. A low `oc_raw` before that count is reached discards the partial count.
- R2: Only cycles with `tick` = 1 advance any timer. While `tick` = 0 the qualification count and the retry count hold their values.
- R3: When recovery mode was off at qualification, `drv_en` stays 0 and `oc_stat` stays 1 until `stat_clr` is pulsed, whatever `oc_raw` does.
- R4: A `stat_clr` pulse clears `oc_stat` on the next edge and restarts qualification from zero. If `oc_raw` is still high, the output is driven for a further QUAL_TICKS ticks before it trips again.
- R5: When `rcv_en` = 1 at qualification, a retry period of PER_SLOW ticks (`freq_sel` = 0) or PER_FAST ticks (`freq_sel` = 1) starts from zero. `drv_en` follows `out_req` only in the final on-window of each period, and `oc_stat` stays 1 throughout.
- R6: The on-window is period/8 ticks when `duty_sel` = 0 and period/4 ticks when `duty_sel` = 1, using integer division. The remaining ticks of the period are off.
- R7: A fault that qualifies again during an on-window ends that window at once and restarts the period count from zero.
- R8: Clearing `rcv_en` during a retry period lets the current period finish, including its on-window. From the next period boundary on, the output stays latched off as in R3.
- R9: With `out_req` = 0, `drv_en` is 0 and no overcurrent is qualified.
- R10: A synchronous active-low reset clears `oc_stat` and all counters. After reset, `drv_en` equals `out_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-base enable; one pulse per timer step |
| oc_raw | input | 1 | Unfiltered overcurrent comparator flag |
| out_req | input | 1 | Requested output state |
| rcv_en | input | 1 | Recovery (automatic retry) mode enable |
| duty_sel | input | 1 | On-window select: 0 = period/8, 1 = period/4 |
| freq_sel | input | 1 | Retry period select: 0 = PER_SLOW, 1 = PER_FAST |
| stat_clr | input | 1 | One-cycle strobe that clears the status bit |
| drv_en | output | 1 | Gated drive enable for the power stage |
| oc_stat | output | 1 | Latched overcurrent status |

## Verification
The bench sends overcurrent bursts one tick shorter than the filter and checks that no fault latches. A design that kept a partial count would trip early on the second burst. It clears the status while the comparator is still high, to catch a design that skips requalification or never drives again. In retry mode it checks the first driven tick and the last off tick at both duty and both rate settings, so a window that is off by one or a swapped period shows up at once. It also checks that a fault inside an on-window restarts the whole off time rather than resuming mid-period. Finally it drops recovery mid-period, to catch a design that cuts the last retry short or keeps pulsing forever.

// File: rtl/ocp_retry_ctrl.sv
module ocp_retry_ctrl #(
  parameter int QUAL_TICKS = 32,
  parameter int PER_SLOW   = 333,
  parameter int PER_FAST   = 167
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic oc_raw,
  input  logic out_req,
  input  logic rcv_en,
  input  logic duty_sel,
  input  logic freq_sel,
  input  logic stat_clr,
  output logic drv_en,
  output logic oc_stat
);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam int RW = $clog2(PER_SLOW + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_TICKS - 1);
  localparam logic [RW-1:0] PS = RW'(PER_SLOW);
  localparam logic [RW-1:0] PF = RW'(PER_FAST);

  logic [QW-1:0] qcnt;
  logic [RW-1:0] rcnt;
  logic          rty;

  logic [RW-1:0] per, on_len, off_len;
  logic          in_on, qual_hit, wrap;

  assign per      = freq_sel ? PF : PS;
  assign on_len   = duty_sel ? (per >> 2) : (per >> 3);
  assign off_len  = per - on_len;
  assign in_on    = rcnt >= off_len;
  assign drv_en   = out_req & (~oc_stat | (rty & in_on));
  assign qual_hit = tick & oc_raw & drv_en & (qcnt == QLAST);
  assign wrap     = tick & rty & (rcnt >= per - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qcnt    <= '0;
      rcnt    <= '0;
      rty     <= 1'b0;
      oc_stat <= 1'b0;
    end else begin
      if (qual_hit || stat_clr || !oc_raw || !drv_en)
        qcnt <= '0;
      else if (tick)
        qcnt <= qcnt + 1'b1;

      if (qual_hit) begin
        oc_stat <= 1'b1;
        rty     <= rcv_en;
        rcnt    <= '0;
      end else if (stat_clr) begin
        oc_stat <= 1'b0;
        rty     <= 1'b0;
        rcnt    <= '0;
      end else if (wrap) begin
        rty  <= rcv_en;
        rcnt <= '0;
      end else if (tick && rty) begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ocp_retry_chk.sv
module ocp_retry_chk #(
  parameter int QUAL_TICKS = 32,
  parameter int PER_SLOW   = 333,
  parameter int QW         = 6,
  parameter int RW         = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          oc_raw,
  input logic          out_req,
  input logic          stat_clr,
  input logic          drv_en,
  input logic          oc_stat,
  input logic [QW-1:0] qcnt,
  input logic [RW-1:0] rcnt,
  input logic          rty
);
  localparam logic [QW-1:0] QLIM = QW'(QUAL_TICKS);
  localparam logic [RW-1:0] RLIM = RW'(PER_SLOW);

  p_req_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req |-> !drv_en);

  p_qual_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_stat) |-> ($past(oc_raw) && $past(drv_en) && $past(tick)));

  p_qbound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt < QLIM);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_stat && !stat_clr) |=> oc_stat);

  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !oc_raw) |=> !oc_stat);

  p_retry_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_stat && drv_en) |-> rty);

  p_rbound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt < RLIM);

  p_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!oc_stat && qcnt == '0 && rcnt == '0));
endmodule

bind ocp_retry_ctrl ocp_retry_chk #(
  .QUAL_TICKS(QUAL_TICKS), .PER_SLOW(PER_SLOW), .QW(QW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .oc_raw(oc_raw), .out_req(out_req),
  .stat_clr(stat_clr), .drv_en(drv_en), .oc_stat(oc_stat),
  .qcnt(qcnt), .rcnt(rcnt), .rty(rty)
);

// File: tb/ocp_retry_ctrl_tb.sv
module ocp_retry_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, oc_raw = 1'b0, out_req = 1'b0, rcv_en = 1'b0;
  logic duty_sel = 1'b0, freq_sel = 1'b0, stat_clr = 1'b0;
  logic drv_en, oc_stat;

  always #4 clk = ~clk;

  ocp_retry_ctrl #(.QUAL_TICKS(4), .PER_SLOW(32), .PER_FAST(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .oc_raw(oc_raw), .out_req(out_req),
    .rcv_en(rcv_en), .duty_sel(duty_sel), .freq_sel(freq_sel),
    .stat_clr(stat_clr), .drv_en(drv_en), .oc_stat(oc_stat)
  );

  typedef struct {
    logic  d;
    logic  s;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input int n, input logic d, input logic s, input string tag);
    exp_t e;
    repeat (n) @(negedge clk);
    e.d = d; e.s = s; e.tag = tag;
    q.push_back(e);
    #3;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (drv_en !== e.d || oc_stat !== e.s) begin
          failures++;
          $display("FAIL %s: drv_en=%0b oc_stat=%0b expected drv_en=%0b oc_stat=%0b",
                   e.tag, drv_en, oc_stat, e.d, e.s);
        end
      end
    end
  end

  task automatic clear_fault();
    stat_clr = 1'b1; oc_raw = 1'b0;
    chk(1, 1'b1, 1'b0, "R4 clear");
    stat_clr = 1'b0;
  endtask

  initial begin
    chk(3, 1'b0, 1'b0, "R10 reset state");
    rst_n = 1'b1;

    oc_raw = 1'b1; out_req = 1'b0;
    chk(6, 1'b0, 1'b0, "R9 no request no drive");

    out_req = 1'b1;
    chk(3, 1'b1, 1'b0, "R1 burst below filter");
    oc_raw = 1'b0;
    chk(1, 1'b1, 1'b0, "R1 burst dropped");
    oc_raw = 1'b1;
    chk(3, 1'b1, 1'b0, "R1 partial count discarded");
    chk(1, 1'b0, 1'b1, "R1 qualified trip");
    chk(40, 1'b0, 1'b1, "R3 latched off");
    oc_raw = 1'b0;
    chk(10, 1'b0, 1'b1, "R3 latched with flag low");

    oc_raw = 1'b1; stat_clr = 1'b1;
    chk(1, 1'b1, 1'b0, "R4 clear under overload");
    stat_clr = 1'b0;
    chk(3, 1'b1, 1'b0, "R4 full requalification");
    chk(1, 1'b0, 1'b1, "R4 retrip");

    clear_fault();
    tick = 1'b0; oc_raw = 1'b1;
    chk(10, 1'b1, 1'b0, "R2 no tick no count");
    tick = 1'b1;
    chk(3, 1'b1, 1'b0, "R2 counting resumes");
    chk(1, 1'b0, 1'b1, "R2 trip after ticks");

    rcv_en = 1'b1; duty_sel = 1'b0; freq_sel = 1'b0;
    clear_fault();
    oc_raw = 1'b1;
    chk(3, 1'b1, 1'b0, "R5 before trip");
    chk(1, 1'b0, 1'b1, "R5 trip enters retry");
    chk(27, 1'b0, 1'b1, "R6 slow duty0 last off tick");
    chk(1, 1'b1, 1'b1, "R5 slow on-window start");
    chk(3, 1'b1, 1'b1, "R6 slow duty0 last on tick");
    chk(1, 1'b0, 1'b1, "R6 slow duty0 window end");
    chk(27, 1'b0, 1'b1, "R5 second period off");
    chk(1, 1'b1, 1'b1, "R5 second period on");

    clear_fault();
    duty_sel = 1'b1; oc_raw = 1'b1;
    chk(3, 1'b1, 1'b0, "R6 before trip");
    chk(1, 1'b0, 1'b1, "R6 trip duty1");
    chk(23, 1'b0, 1'b1, "R6 slow duty1 last off tick");
    chk(1, 1'b1, 1'b1, "R6 slow duty1 on-window start");
    chk(3, 1'b1, 1'b1, "R7 on while requalifying");
    chk(1, 1'b0, 1'b1, "R7 retrip cuts window");
    chk(23, 1'b0, 1'b1, "R7 full off time after cut");
    chk(1, 1'b1, 1'b1, "R7 restarted period on");
    oc_raw = 1'b0;
    chk(7, 1'b1, 1'b1, "R6 full duty1 window without fault");
    chk(1, 1'b0, 1'b1, "R5 period wrap status kept");

    clear_fault();
    freq_sel = 1'b1; duty_sel = 1'b0; oc_raw = 1'b1;
    chk(3, 1'b1, 1'b0, "R5 fast before trip");
    chk(1, 1'b0, 1'b1, "R5 fast trip");
    chk(13, 1'b0, 1'b1, "R5 fast last off tick");
    chk(1, 1'b1, 1'b1, "R5 fast on-window start");
    chk(1, 1'b1, 1'b1, "R6 fast duty0 second on tick");
    chk(1, 1'b0, 1'b1, "R6 fast duty0 window end");

    rcv_en = 1'b0;
    chk(13, 1'b0, 1'b1, "R8 off part of final period");
    chk(1, 1'b1, 1'b1, "R8 final retry still runs");
    chk(1, 1'b1, 1'b1, "R8 final retry second tick");
    chk(1, 1'b0, 1'b1, "R8 final window end");
    chk(40, 1'b0, 1'b1, "R8 latched off afterwards");

    rst_n = 1'b0; oc_raw = 1'b0;
    chk(1, 1'b1, 1'b0, "R10 reset clears status");
    rst_n = 1'b1;
    chk(5, 1'b1, 1'b0, "R10 drive follows request");

    @(negedge clk); #4;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule